// File: doc/BRIEF.md
# Protection Region Descriptor Register File

This block is the storage side of a memory protection unit. It keeps a set of region descriptors and one unit-wide enable bit, and presents them through a small register port: a synchronous write port whose every write carries the ID of the issuing bus master, and a combinational read port. Each descriptor holds a start address, an end address, a packed access-rights word, a valid bit and a process identifier with its mask.

The stored fields are also driven out continuously, already split into per-master fields, so that a separate access checker can compare bus traffic against them without decoding the rights word itself. Region bounds are kept at 32-byte granularity. Region 0 is shielded from the core (master 0): the core cannot move its bounds or change the debugger's (master 1) rights, so the debugger keeps access to the whole address space whatever software does.

Register map (word addresses): address 0 is the unit control word. Region r occupies addresses 8+8r to 8+8r+4: offset 0 start, 1 end, 2 rights, 3 valid, 4 process identifier. Offsets 5 to 7 and addresses 1 to 7 are unmapped.

Top module: `mpu_region_file`

## Requirements
- R1: After reset, region 0 has start 0x00000000, end 0xFFFFFFFF, rights 0xFF1C71C7 (user rights 7 and supervisor rights 0 for masters 0 to 3, read/write 2'b11 for masters 4 to 7) and valid 1; every other region has start 0, end 0x0000001F, rights 0 and valid 0; the unit enable is 0.
- R2: Control word bits [9:8] read 0, 1 or 2 for 8, 12 or 16 regions; writes do not change them.
- R3: A start address reads back and is driven out with bits [4:0] at 0.
- R4: An end address reads back and is driven out with bits [4:0] at 1.
- R5: In the rights word, master n of 0..3 has a 5-bit rights field at bit 6n and a process-identifier enable at bit 6n+5; master n of 4..7 has a 2-bit read/write field at bit 2(n-4)+24; the decoded outputs follow this layout.
- R6: A write from master 0 to region 0 leaves its start, its end and rights bits [11:6] unchanged, and updates the other rights bits.
- R7: Writes from any master other than 0 update all fields of region 0.
- R8: Each region's valid bit is bit 0 of its offset-3 word, writable by every master, region 0 included.
- R9: Control word bit 0 is the unit enable, readable and writable by every master.
- R10: The offset-4 word holds the process identifier in bits [7:0] and its mask in bits [15:8]; bits [31:16] read 0.
- R11: Unmapped addresses read 0 and writes to them change nothing.
- R12: A write shows on the read port and the descriptor outputs from the clock edge that samples it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_wr_en | input | 1 | Write strobe |
| i_wr_addr | input | AW | Write word address |
| i_wr_mid | input | MID_W | Master ID of the writer |
| i_wr_data | input | 32 | Write data |
| i_rd_addr | input | AW | Read word address |
| o_rd_data | output | 32 | Read data (combinational) |
| o_unit_en | output | 1 | Unit-wide enable |
| o_region_valid | output | NUM_REGIONS | Per-region valid |
| o_region_start | output | NUM_REGIONS*32 | Start addresses, region r at [32r +: 32] |
| o_region_end | output | NUM_REGIONS*32 | End addresses, region r at [32r +: 32] |
| o_priv_rights | output | NUM_REGIONS*20 | 5-bit rights, region r master m at [(4r+m)*5 +: 5] |
| o_priv_pid_en | output | NUM_REGIONS*4 | Process-ID enable, region r master m at [4r+m] |
| o_norm_rw | output | NUM_REGIONS*8 | Read/write, region r master 4+m at [(4r+m)*2 +: 2] |
| o_pid | output | NUM_REGIONS*8 | Process identifier per region |
| o_pid_mask | output | NUM_REGIONS*8 | Process identifier mask per region |

## Verification
A descriptor holding a wrong value is visible at the read port in the same cycle the address is presented, and on the flat descriptor outputs continuously, so any storage or filter fault appears one clock after the write that caused it. A leaky core filter on region 0 shows as a moved bound or a changed debugger field on the very next read, and a wrong decode shows as a field on the checker outputs that disagrees with the rights word read back at offset 2.

// File: rtl/mpu_desc_pkg.sv
package mpu_desc_pkg;

    localparam int unsigned DW          = 32;
    localparam int unsigned GRAN_BITS   = 5;
    localparam int unsigned N_PRIV      = 4;
    localparam int unsigned N_NORM      = 4;
    localparam int unsigned PRIV_W      = 5;
    localparam int unsigned PRIV_STRIDE = 6;
    localparam int unsigned NORM_W      = 2;
    localparam int unsigned NORM_BASE   = 24;
    localparam int unsigned CORE_ID     = 0;
    localparam int unsigned DEBUG_ID    = 1;
    localparam int unsigned REGION_BASE = 8;
    localparam int unsigned MID_W       = 3;

    // Debugger rights field plus its process-ID enable bit
    localparam logic [DW-1:0] DBG_MASK = 32'h3F << (DEBUG_ID * PRIV_STRIDE);

    typedef enum logic [2:0] {
        W_START  = 3'd0,
        W_END    = 3'd1,
        W_RIGHTS = 3'd2,
        W_VALID  = 3'd3,
        W_PID    = 3'd4
    } dword_e;

    typedef struct packed {
        logic [DW-1:0] start;
        logic [DW-1:0] fin;
        logic [DW-1:0] rights;
        logic          valid;
        logic [7:0]    pid;
        logic [7:0]    pid_mask;
    } desc_t;

    function automatic logic [1:0] count_code(int unsigned n);
        if (n <= 8)       return 2'd0;
        else if (n <= 12) return 2'd1;
        else              return 2'd2;
    endfunction

    // Full rights: user RWX (3'b111, low bits), supervisor code 0; read+write for normal masters
    function automatic logic [DW-1:0] full_rights();
        logic [DW-1:0] r;
        r = '0;
        for (int m = 0; m < int'(N_PRIV); m++)
            r[m*PRIV_STRIDE +: PRIV_W] = 5'b00111;
        for (int m = 0; m < int'(N_NORM); m++)
            r[NORM_BASE + m*NORM_W +: NORM_W] = 2'b11;
        return r;
    endfunction

    function automatic desc_t reset_desc(bit is_zero);
        desc_t d;
        d.start    = '0;
        d.fin      = is_zero ? '1 : {{(DW-GRAN_BITS){1'b0}}, {GRAN_BITS{1'b1}}};
        d.rights   = is_zero ? full_rights() : '0;
        d.valid    = is_zero;
        d.pid      = '0;
        d.pid_mask = '0;
        return d;
    endfunction

endpackage

// File: rtl/mpu_desc_slot.sv
module mpu_desc_slot
    import mpu_desc_pkg::*;
#(
    parameter bit IS_ZERO = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_we,
    input  dword_e        i_word,
    input  logic [DW-1:0] i_wdata,
    input  logic          i_core_wr,
    output desc_t         o_desc
);

    desc_t q;
    logic  locked;

    assign locked = IS_ZERO && i_core_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= reset_desc(IS_ZERO);
        end else if (i_we) begin
            case (i_word)
                W_START:  if (!locked) q.start <= {i_wdata[DW-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
                W_END:    if (!locked) q.fin   <= {i_wdata[DW-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
                W_RIGHTS: q.rights <= locked ? ((i_wdata & ~DBG_MASK) | (q.rights & DBG_MASK))
                                             : i_wdata;
                W_VALID:  q.valid <= i_wdata[0];
                W_PID: begin
                    q.pid      <= i_wdata[7:0];
                    q.pid_mask <= i_wdata[15:8];
                end
                default: ;
            endcase
        end
    end

    assign o_desc = q;

    AST_CORE_BOUNDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (IS_ZERO && i_we && i_core_wr && (i_word == W_START || i_word == W_END))
        |=> ($stable(o_desc.start) && $stable(o_desc.fin))); // R6

    AST_DBG_FIELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (IS_ZERO && i_we && i_core_wr && i_word == W_RIGHTS)
        |=> ((o_desc.rights & DBG_MASK) == ($past(o_desc.rights) & DBG_MASK))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !i_we |=> $stable(o_desc)); // R12

    AST_VALID_ANY_MASTER: assert property (@(posedge clk) disable iff (rst)
        (i_we && i_word == W_VALID) |=> (o_desc.valid == $past(i_wdata[0]))); // R8

endmodule

// File: rtl/mpu_desc_decode.sv
module mpu_desc_decode
    import mpu_desc_pkg::*;
(
    input  logic [DW-1:0]               i_rights,
    output logic [N_PRIV*PRIV_W-1:0]    o_priv,
    output logic [N_PRIV-1:0]           o_pid_en,
    output logic [N_NORM*NORM_W-1:0]    o_norm
);

    for (genvar m = 0; m < int'(N_PRIV); m++) begin : g_priv
        assign o_priv[m*PRIV_W +: PRIV_W] = i_rights[m*PRIV_STRIDE +: PRIV_W];
        assign o_pid_en[m]                = i_rights[m*PRIV_STRIDE + PRIV_W];
    end

    for (genvar m = 0; m < int'(N_NORM); m++) begin : g_norm
        assign o_norm[m*NORM_W +: NORM_W] = i_rights[NORM_BASE + m*NORM_W +: NORM_W];
    end

endmodule

// File: rtl/mpu_rd_mux.sv
module mpu_rd_mux
    import mpu_desc_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 16,
    parameter int unsigned AW          = 8
) (
    input  logic [AW-1:0] i_addr,
    input  desc_t         i_descs [NUM_REGIONS],
    input  logic          i_unit_en,
    output logic [DW-1:0] o_rdata
);

    localparam logic [1:0] CODE = count_code(NUM_REGIONS);

    always_comb begin
        int unsigned idx;
        idx     = int'(i_addr[AW-1:3]) - 1;
        o_rdata = '0;
        if (i_addr == '0) begin
            o_rdata[0]   = i_unit_en;
            o_rdata[9:8] = CODE;
        end else if (i_addr[AW-1:3] != '0 && idx < NUM_REGIONS) begin
            case (i_addr[2:0])
                3'(W_START):  o_rdata = i_descs[idx].start;
                3'(W_END):    o_rdata = i_descs[idx].fin;
                3'(W_RIGHTS): o_rdata = i_descs[idx].rights;
                3'(W_VALID):  o_rdata[0] = i_descs[idx].valid;
                3'(W_PID):    o_rdata[15:0] = {i_descs[idx].pid_mask, i_descs[idx].pid};
                default:      o_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mpu_region_file.sv
module mpu_region_file
    import mpu_desc_pkg::*;
#(
    parameter  int unsigned NUM_REGIONS = 16,
    localparam int unsigned AW          = $clog2(REGION_BASE + 8*NUM_REGIONS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            i_wr_en,
    input  logic [AW-1:0]                   i_wr_addr,
    input  logic [MID_W-1:0]                i_wr_mid,
    input  logic [31:0]                     i_wr_data,
    input  logic [AW-1:0]                   i_rd_addr,
    output logic [31:0]                     o_rd_data,
    output logic                            o_unit_en,
    output logic [NUM_REGIONS-1:0]          o_region_valid,
    output logic [NUM_REGIONS*32-1:0]       o_region_start,
    output logic [NUM_REGIONS*32-1:0]       o_region_end,
    output logic [NUM_REGIONS*20-1:0]       o_priv_rights,
    output logic [NUM_REGIONS*4-1:0]        o_priv_pid_en,
    output logic [NUM_REGIONS*8-1:0]        o_norm_rw,
    output logic [NUM_REGIONS*8-1:0]        o_pid,
    output logic [NUM_REGIONS*8-1:0]        o_pid_mask
);

    localparam int unsigned PRIV_BITS = N_PRIV * PRIV_W;
    localparam int unsigned NORM_BITS = N_NORM * NORM_W;

    desc_t  descs [NUM_REGIONS];
    logic   core_wr;
    logic   unit_en_q;
    dword_e wr_word;

    assign core_wr = (i_wr_mid == MID_W'(CORE_ID));
    assign wr_word = dword_e'(i_wr_addr[2:0]);

    always_ff @(posedge clk) begin
        if (rst)                            unit_en_q <= 1'b0;
        else if (i_wr_en && i_wr_addr == '0) unit_en_q <= i_wr_data[0];
    end
    assign o_unit_en = unit_en_q;

    for (genvar r = 0; r < int'(NUM_REGIONS); r++) begin : g_region
        logic hit;
        assign hit = i_wr_en && (i_wr_addr[AW-1:3] == (AW-3)'(r + 1))
                     && (i_wr_addr[2:0] <= 3'(W_PID));

        mpu_desc_slot #(.IS_ZERO(r == 0)) i_slot (
            .clk      (clk),
            .rst      (rst),
            .i_we     (hit),
            .i_word   (wr_word),
            .i_wdata  (i_wr_data),
            .i_core_wr(core_wr),
            .o_desc   (descs[r])
        );

        mpu_desc_decode i_dec (
            .i_rights (descs[r].rights),
            .o_priv   (o_priv_rights[r*PRIV_BITS +: PRIV_BITS]),
            .o_pid_en (o_priv_pid_en[r*N_PRIV +: N_PRIV]),
            .o_norm   (o_norm_rw[r*NORM_BITS +: NORM_BITS])
        );

        assign o_region_valid[r]        = descs[r].valid;
        assign o_region_start[r*32 +: 32] = descs[r].start;
        assign o_region_end[r*32 +: 32]   = descs[r].fin;
        assign o_pid[r*8 +: 8]           = descs[r].pid;
        assign o_pid_mask[r*8 +: 8]      = descs[r].pid_mask;
    end

    mpu_rd_mux #(.NUM_REGIONS(NUM_REGIONS), .AW(AW)) i_rd (
        .i_addr   (i_rd_addr),
        .i_descs  (descs),
        .i_unit_en(unit_en_q),
        .o_rdata  (o_rd_data)
    );

    AST_START_GRANULE: assert property (@(posedge clk) disable iff (rst)
        (i_rd_addr[AW-1:3] != '0 && i_rd_addr[2:0] == 3'(W_START)) |-> (o_rd_data[4:0] == 5'd0)); // R3

    AST_END_GRANULE: assert property (@(posedge clk) disable iff (rst)
        (i_rd_addr[AW-1:3] != '0 && int'(i_rd_addr[AW-1:3]) <= int'(NUM_REGIONS)
         && i_rd_addr[2:0] == 3'(W_END)) |-> (o_rd_data[4:0] == 5'h1F)); // R4

    AST_INFO_CODE: assert property (@(posedge clk) disable iff (rst)
        (i_rd_addr == '0) |-> (o_rd_data[9:8] == count_code(NUM_REGIONS))); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (i_rd_addr[AW-1:3] == '0 && i_rd_addr != '0) |-> (o_rd_data == '0)); // R11

endmodule

// File: tb/test_mpu_region_file.sv
module test_mpu_region_file;
    import mpu_desc_pkg::*;

    localparam int NREG = 16;
    localparam int AW   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [2:0]        wr_mid = '0;
    logic [31:0]       wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [31:0]       rd_data;
    logic              unit_en;
    logic [NREG-1:0]   rvalid;
    logic [NREG*32-1:0] rstart, rend;
    logic [NREG*20-1:0] priv;
    logic [NREG*4-1:0]  pid_en;
    logic [NREG*8-1:0]  norm, pid, pmask;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mpu_region_file #(.NUM_REGIONS(NREG)) i_mpu_region_file (
        .clk(clk), .rst(rst), .i_wr_en(wr_en), .i_wr_addr(wr_addr),
        .i_wr_mid(wr_mid), .i_wr_data(wr_data), .i_rd_addr(rd_addr),
        .o_rd_data(rd_data), .o_unit_en(unit_en), .o_region_valid(rvalid),
        .o_region_start(rstart), .o_region_end(rend), .o_priv_rights(priv),
        .o_priv_pid_en(pid_en), .o_norm_rw(norm), .o_pid(pid), .o_pid_mask(pmask)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [2:0]  mid;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        '{1'b0,   8'd9, 3'd0, 32'hFFFFFFFF},  // R1 region 0 end
        '{1'b0,   8'd8, 3'd0, 32'h00000000},  // R1 region 0 start
        '{1'b0,  8'd10, 3'd0, 32'hFF1C71C7},  // R1 region 0 rights
        '{1'b0,  8'd11, 3'd0, 32'h00000001},  // R1 region 0 valid
        '{1'b0,  8'd25, 3'd0, 32'h0000001F},  // R1 region 2 end
        '{1'b0,  8'd27, 3'd0, 32'h00000000},  // R1 region 2 valid
        '{1'b0,   8'd0, 3'd0, 32'h00000200},  // R2 code, R9 disabled
        '{1'b1,   8'd0, 3'd0, 32'hFFFFFFFF},
        '{1'b0,   8'd0, 3'd0, 32'h00000201},  // R2 code unchanged, R9 enabled
        '{1'b1,  8'd16, 3'd2, 32'h12345678},
        '{1'b0,  8'd16, 3'd0, 32'h12345660},  // R3
        '{1'b1,  8'd17, 3'd2, 32'h20000000},
        '{1'b0,  8'd17, 3'd0, 32'h2000001F},  // R4
        '{1'b1,  8'd18, 3'd0, 32'hA5A5A5A5},
        '{1'b0,  8'd18, 3'd0, 32'hA5A5A5A5},  // R5 core writes non-zero region freely
        '{1'b1,  8'd19, 3'd0, 32'hFFFFFFFF},
        '{1'b0,  8'd19, 3'd0, 32'h00000001},  // R8
        '{1'b1,  8'd20, 3'd3, 32'hFFFFABCD},
        '{1'b0,  8'd20, 3'd0, 32'h0000ABCD},  // R10
        '{1'b1,   8'd8, 3'd0, 32'h40000000},
        '{1'b0,   8'd8, 3'd0, 32'h00000000},  // R6 start kept
        '{1'b1,   8'd9, 3'd0, 32'h00001000},
        '{1'b0,   8'd9, 3'd0, 32'hFFFFFFFF},  // R6 end kept
        '{1'b1,  8'd10, 3'd0, 32'h00000000},
        '{1'b0,  8'd10, 3'd0, 32'h000001C0},  // R6 debugger field kept
        '{1'b1,  8'd11, 3'd0, 32'h00000000},
        '{1'b0,  8'd11, 3'd0, 32'h00000000},  // R8 core clears region 0 valid
        '{1'b1,  8'd11, 3'd0, 32'h00000001},
        '{1'b0,  8'd11, 3'd0, 32'h00000001},  // R8
        '{1'b1,   8'd8, 3'd1, 32'h00001234},
        '{1'b0,   8'd8, 3'd0, 32'h00001220},  // R7 debugger moves start
        '{1'b1,  8'd10, 3'd1, 32'hFFFFFFFF},
        '{1'b0,  8'd10, 3'd0, 32'hFFFFFFFF},  // R7
        '{1'b1,  8'd10, 3'd0, 32'h00000000},
        '{1'b0,  8'd10, 3'd0, 32'h00000FC0},  // R6 other fields cleared
        '{1'b1,   8'd9, 3'd5, 32'h00007FFF},
        '{1'b0,   8'd9, 3'd0, 32'h00007FFF},  // R7 other master moves end
        '{1'b1,  8'd13, 3'd1, 32'hFFFFFFFF},
        '{1'b0,  8'd13, 3'd0, 32'h00000000},  // R11
        '{1'b0,   8'd3, 3'd0, 32'h00000000},  // R11
        '{1'b0, 8'd200, 3'd0, 32'h00000000},  // R11
        '{1'b1,   8'd5, 3'd1, 32'hFFFFFFFF},
        '{1'b0,   8'd0, 3'd0, 32'h00000201},  // R11 control untouched
        '{1'b1, 8'd129, 3'd4, 32'h00000000},
        '{1'b0, 8'd129, 3'd0, 32'h0000001F},  // R4 last region
        '{1'b1, 8'd128, 3'd4, 32'hFFFFFFFF},
        '{1'b0, 8'd128, 3'd0, 32'hFFFFFFE0},  // R3 last region
        '{1'b1,  8'd28, 3'd0, 32'hFFFF1111},
        '{1'b0,  8'd28, 3'd0, 32'h00001111},  // R10 upper bits zero
        '{1'b1,   8'd0, 3'd2, 32'h00000000},
        '{1'b0,   8'd0, 3'd0, 32'h00000200}   // R9 cleared by another master
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [2:0] m, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_mid = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 unit enable at reset", {31'b0, unit_en}, 32'h0);
        check("R1 valid vector at reset", {16'b0, rvalid}, 32'h0001);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].addr, VEC[i].mid, VEC[i].data);
            end else begin
                rd_addr = VEC[i].addr;
                #1;
                check($sformatf("vector %0d addr %0d", i, VEC[i].addr), rd_data, VEC[i].data);
                @(negedge clk);
            end
        end

        // R5 decoded rights of region 1 from 0xA5A5A5A5
        rv = 32'hA5A5A5A5;
        for (int m = 0; m < 4; m++) begin
            check($sformatf("R5 priv rights m%0d", m), {27'b0, priv[(4+m)*5 +: 5]}, {27'b0, rv[6*m +: 5]});
            check($sformatf("R5 pid enable m%0d", m), {31'b0, pid_en[4+m]}, {31'b0, rv[6*m+5]});
            check($sformatf("R5 normal rw m%0d", m+4), {30'b0, norm[(4+m)*2 +: 2]}, {30'b0, rv[24+2*m +: 2]});
        end
        check("R3 start output region 1", rstart[32 +: 32], 32'h12345660);
        check("R4 end output region 1", rend[32 +: 32], 32'h2000001F);
        check("R10 pid output region 1", {24'b0, pid[8 +: 8]}, 32'hCD);
        check("R10 mask output region 1", {24'b0, pmask[8 +: 8]}, 32'hAB);
        check("R8 valid vector", {16'b0, rvalid}, 32'h0003);
        check("R9 unit enable output", {31'b0, unit_en}, 32'h0);

        // R12 timing: not visible before the sampling edge, visible after
        wr_en = 1'b1; wr_addr = 8'd24; wr_mid = 3'd2; wr_data = 32'h80000000;
        rd_addr = 8'd24;
        #1;
        check("R12 before edge output", rstart[64 +: 32], 32'h0);
        check("R12 before edge read", rd_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R12 after edge output", rstart[64 +: 32], 32'h80000000);
        check("R12 after edge read", rd_data, 32'h80000000);

        // R1 reset in mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_addr = 8'd10;
        #1;
        check("R1 rights after reset", rd_data, 32'hFF1C71C7);
        check("R1 valid after reset", {16'b0, rvalid}, 32'h0001);
        check("R1 region 0 end after reset", rend[0 +: 32], 32'hFFFFFFFF);
        check("R1 region 1 start after reset", rstart[32 +: 32], 32'h0);
        check("R1 region 1 end after reset", rend[32 +: 32], 32'h1F);
        check("R1 unit enable after reset", {31'b0, unit_en}, 32'h0);

        summary();
        $finish;
    end

endmodule